// File: doc/BRIEF.md
# Fragmenting Mailbox Message Transmitter

The block accepts one message at a time, held as a run of bytes together with a host address and a client address, and delivers it into a word-wide slot mailbox. It first stores the whole message internally, so that any attempt can be replayed from the first byte. It then cuts the message into fragments. Each fragment is a 32-bit header word followed by the payload words. The fragment size comes from the mailbox depth the peer reports and from the 9-bit length field of the header. Before it writes anything, the engine waits until the mailbox reports enough free slots. It rings a doorbell after each fragment and then checks that the peer is still ready.

An attempt fails if the peer drops ready after a doorbell, or if the wait for peer ready or for free slots lasts too long. A failed attempt restarts the message from its first fragment. After `MAX_TRIES` failed attempts the engine pulses an error. The mailbox side has no backpressure beyond its free-slot count: a push is one cycle with one word.

The controller is a single state machine with these states: `ST_IDLE`, `ST_LOAD` (accept the bytes), `ST_READY_WAIT` (wait for peer ready and sample the depth), `ST_HDR_WAIT` (wait for one free slot), `ST_HDR_PUSH` (write the header), `ST_BODY_WAIT` (wait for enough slots for the whole payload), `ST_BODY_PUSH` (write the payload words), `ST_RING` (doorbell), `ST_CHECK` (peer still ready?), `ST_RETRY` (count the failed attempt), `ST_DONE` and `ST_FAIL`.

The transitions are:
- IDLE goes to LOAD on a valid start, or to FAIL on a rejected length.
- LOAD goes to READY_WAIT after the last byte.
- READY_WAIT goes to HDR_WAIT when the peer is ready, or to RETRY on timeout.
- HDR_WAIT goes to HDR_PUSH when a slot is free, or to RETRY on timeout.
- HDR_PUSH goes to BODY_WAIT.
- BODY_WAIT goes to BODY_PUSH when enough slots are free, or to RETRY on timeout.
- BODY_PUSH goes to RING after the last word.
- RING goes to CHECK.
- CHECK goes to RETRY if the peer is not ready, to DONE if the message is finished, and otherwise to HDR_WAIT.
- RETRY goes to FAIL once the attempts are used up, and otherwise to READY_WAIT.
- DONE and FAIL go back to IDLE.

Top module: `tx_frag_engine`

## Requirements
- R1: Each header word carries the fragment payload length in bytes in bits 24:16, the host address in bits 15:8 and the client address in bits 7:0. Bits 30:25 are zero.
- R2: The largest fragment payload is min(4 × depth, 511) − 4 bytes. The depth is sampled when the peer ready flag is seen at the start of an attempt. Each fragment carries min(that cap, bytes not yet sent).
- R3: Bit 31 of a header is 1 only in the header of the fragment that carries the last byte of the message. It is 0 in all other headers.
- R4: A header is pushed only after the free-slot count is at least 1. The payload words are pushed only after the free-slot count is at least ceil(length/4), so the mailbox never overflows.
- R5: Payload bytes are packed little-endian: the first byte of a word goes in bits 7:0. In the last word of a fragment, the byte lanes past the fragment length are zero.
- R6: The doorbell is a one-cycle pulse in the cycle after the last payload word of each fragment. If peer ready is low in the cycle that follows the doorbell, the fragment fails.
- R7: A failed attempt restarts the message from its first fragment. After `MAX_TRIES` (5) failed attempts, `error_o` pulses for one cycle and no further attempt starts.
- R8: A start with a length of 0 or greater than `MAX_LEN` gives an error pulse in the next cycle. No byte is accepted and no word is pushed.
- R9: The attempt is aborted when peer ready stays low for `WAIT_LIMIT` cycles. It is also aborted when the free-slot count stays too small for `WAIT_LIMIT` cycles.
- R10: After reset the block is idle: no push, doorbell, done or error, and `in_ready_o` is low. `in_ready_o` is high only while bytes are being loaded. `done_o` pulses once after the last fragment passes its ready check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a message; sampled only when idle |
| msg_len_i | input | $clog2(MAX_LEN+1) | Message length in bytes |
| host_addr_i | input | 8 | Host address for the headers |
| client_addr_i | input | 8 | Client address for the headers |
| in_valid_i | input | 1 | Message byte valid |
| in_data_i | input | 8 | Message byte |
| in_ready_o | output | 1 | Byte accepted when high together with valid |
| mb_depth_i | input | DEPTH_W | Mailbox capacity in slots |
| mb_free_i | input | DEPTH_W | Free slots in the mailbox |
| peer_ready_i | input | 1 | Peer ready flag |
| mb_push_o | output | 1 | Write `mb_word_o` into the next slot |
| mb_word_o | output | 32 | Header or payload word |
| doorbell_o | output | 1 | Fragment-written pulse |
| busy_o | output | 1 | A message is in progress |
| done_o | output | 1 | Message delivered |
| error_o | output | 1 | Message rejected or attempts exhausted |

## Verification
The hardest situation to reach is a retry that happens in the middle of a message, after some fragments have already been accepted. From the ports this needs the peer ready flag to fall in exactly the cycle that follows a chosen doorbell. The bench mailbox model watches the doorbell, drops peer ready on the selected fragment, drops the words logged so far and holds ready low for a short time. It then expects the full fragment sequence to arrive again. The slot timeout is reached by stopping the model's drain, so that the first fragment fills a shallow mailbox. With the drain stopped, the next header can never find a free slot.

// File: rtl/txfrag_pkg.sv
package txfrag_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_READY_WAIT,
        ST_HDR_WAIT,
        ST_HDR_PUSH,
        ST_BODY_WAIT,
        ST_BODY_PUSH,
        ST_RING,
        ST_CHECK,
        ST_RETRY,
        ST_DONE,
        ST_FAIL
    } tx_state_e;

    localparam int SLOT_BYTES  = 4;
    localparam int HDR_LEN_CAP = 511;

    // header word: last flag, six zero bits, 9-bit byte count, host, client
    function automatic logic [31:0] pack_header(input logic       last,
                                                input logic [8:0] nbytes,
                                                input logic [7:0] host,
                                                input logic [7:0] client);
        return {last, 6'b000000, nbytes, host, client};
    endfunction

endpackage

// File: rtl/tx_wait_timer.sv
module tx_wait_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // expires in the LIMIT-th consecutive cycle of a wait
    assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LIMIT - 1)); // R9

endmodule

// File: rtl/tx_frag_sizer.sv
module tx_frag_sizer #(
    parameter int DEPTH_W = 8,
    parameter int LEN_W   = 7
) (
    input  logic [DEPTH_W-1:0] depth_i,
    input  logic [8:0]         cap_i,
    input  logic [LEN_W-1:0]   remaining_i,
    output logic [8:0]         cap_o,
    output logic [8:0]         frag_len_o,
    output logic               frag_last_o,
    output logic [7:0]         frag_words_o
);
    import txfrag_pkg::*;

    localparam int SW = (DEPTH_W + 2 > 10) ? DEPTH_W + 2 : 10;
    localparam int CW = (LEN_W > 10) ? LEN_W + 1 : 11;

    logic [SW-1:0] depth_bytes;
    logic [8:0]    capped;
    logic [9:0]    words_round;

    always_comb begin
        depth_bytes = SW'({depth_i, 2'b00});
        capped      = (depth_bytes > SW'(HDR_LEN_CAP)) ? 9'(HDR_LEN_CAP) : 9'(depth_bytes);
        cap_o       = capped - 9'(SLOT_BYTES);

        frag_last_o  = CW'(remaining_i) <= CW'(cap_i);
        frag_len_o   = frag_last_o ? 9'(remaining_i) : cap_i;
        words_round  = 10'(frag_len_o) + 10'd3;
        frag_words_o = 8'(words_round >> 2);
    end

endmodule

// File: rtl/tx_msg_store.sv
module tx_msg_store #(
    parameter int MAX_LEN = 64,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_base,
    input  logic [2:0]       rd_count,
    output logic [31:0]      rd_word
);
    logic [7:0] mem_q [MAX_LEN];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // little-endian gather; lanes at or beyond rd_count read as zero
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [IDX_W-1:0] pos;
        assign pos = rd_base + IDX_W'(g);
        assign rd_word[8*g +: 8] = (3'(g) < rd_count) ? mem_q[pos] : 8'h00;
    end

endmodule

// File: rtl/tx_frag_engine.sv
module tx_frag_engine #(
    parameter int MAX_LEN    = 64,
    parameter int DEPTH_W    = 8,
    parameter int WAIT_LIMIT = 256,
    parameter int MAX_TRIES  = 5,
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [LEN_W-1:0]   msg_len_i,
    input  logic [7:0]         host_addr_i,
    input  logic [7:0]         client_addr_i,
    input  logic               in_valid_i,
    input  logic [7:0]         in_data_i,
    output logic               in_ready_o,
    input  logic [DEPTH_W-1:0] mb_depth_i,
    input  logic [DEPTH_W-1:0] mb_free_i,
    input  logic               peer_ready_i,
    output logic               mb_push_o,
    output logic [31:0]        mb_word_o,
    output logic               doorbell_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               error_o
);
    import txfrag_pkg::*;

    localparam int IDX_W  = $clog2(MAX_LEN);
    localparam int TRY_W  = $clog2(MAX_TRIES + 1);
    localparam int CW     = (LEN_W > 10) ? LEN_W + 1 : 11;
    localparam int SLOT_W = (DEPTH_W > 8) ? DEPTH_W : 8;

    tx_state_e state_q, state_d;

    logic [LEN_W-1:0] len_q, ld_cnt_q, off_q;
    logic [7:0]       host_q, client_q;
    logic [8:0]       cap_q, flen_q;
    logic [7:0]       nwords_q, widx_q;
    logic [TRY_W-1:0] try_q;

    logic [8:0]       cap_new, frag_len;
    logic             frag_last;
    logic [7:0]       frag_words;
    logic [LEN_W-1:0] remaining;
    logic [CW-1:0]    rem_in_frag;
    logic [2:0]       lane_count;
    logic [IDX_W-1:0] rd_base;
    logic [31:0]      body_word;
    logic             waiting, wait_expired, last_word;
    logic [SLOT_W-1:0] free_ext, words_ext;

    assign remaining   = LEN_W'(len_q - off_q);
    assign rem_in_frag = CW'(flen_q) - CW'({widx_q, 2'b00});
    assign lane_count  = (rem_in_frag >= CW'(4)) ? 3'd4 : 3'(rem_in_frag);
    assign rd_base     = IDX_W'(CW'(off_q) + CW'({widx_q, 2'b00}));
    assign last_word   = (widx_q == nwords_q - 8'd1);
    assign free_ext    = SLOT_W'(mb_free_i);
    assign words_ext   = SLOT_W'(nwords_q);
    assign waiting     = (state_q == ST_READY_WAIT) || (state_q == ST_HDR_WAIT) ||
                         (state_q == ST_BODY_WAIT);

    tx_frag_sizer #(.DEPTH_W(DEPTH_W), .LEN_W(LEN_W)) u_sizer (
        .depth_i      (mb_depth_i),
        .cap_i        (cap_q),
        .remaining_i  (remaining),
        .cap_o        (cap_new),
        .frag_len_o   (frag_len),
        .frag_last_o  (frag_last),
        .frag_words_o (frag_words)
    );

    tx_msg_store #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .wr_en    ((state_q == ST_LOAD) && in_valid_i),
        .wr_idx   (IDX_W'(ld_cnt_q)),
        .wr_data  (in_data_i),
        .rd_base  (rd_base),
        .rd_count (lane_count),
        .rd_word  (body_word)
    );

    tx_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .restart (state_d != state_q),
        .expired (wait_expired)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (msg_len_i == '0 || msg_len_i > LEN_W'(MAX_LEN)) state_d = ST_FAIL;
                    else                                                state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (in_valid_i && (ld_cnt_q + 1'b1) == len_q) state_d = ST_READY_WAIT;
            end
            ST_READY_WAIT: begin
                if (peer_ready_i)      state_d = ST_HDR_WAIT;
                else if (wait_expired) state_d = ST_RETRY;
            end
            ST_HDR_WAIT: begin
                if (free_ext != '0)    state_d = ST_HDR_PUSH;
                else if (wait_expired) state_d = ST_RETRY;
            end
            ST_HDR_PUSH:  state_d = ST_BODY_WAIT;
            ST_BODY_WAIT: begin
                if (free_ext >= words_ext) state_d = ST_BODY_PUSH;
                else if (wait_expired)     state_d = ST_RETRY;
            end
            ST_BODY_PUSH: begin
                if (last_word) state_d = ST_RING;
            end
            ST_RING:  state_d = ST_CHECK;
            ST_CHECK: begin
                if (!peer_ready_i)       state_d = ST_RETRY;
                else if (off_q == len_q) state_d = ST_DONE;
                else                     state_d = ST_HDR_WAIT;
            end
            ST_RETRY: begin
                if (try_q == TRY_W'(MAX_TRIES - 1)) state_d = ST_FAIL;
                else                                 state_d = ST_READY_WAIT;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAIL:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q    <= '0;
            ld_cnt_q <= '0;
            off_q    <= '0;
            host_q   <= '0;
            client_q <= '0;
            cap_q    <= '0;
            flen_q   <= '0;
            nwords_q <= '0;
            widx_q   <= '0;
            try_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        len_q    <= msg_len_i;
                        host_q   <= host_addr_i;
                        client_q <= client_addr_i;
                        ld_cnt_q <= '0;
                        try_q    <= '0;
                    end
                end
                ST_LOAD: begin
                    if (in_valid_i) ld_cnt_q <= ld_cnt_q + 1'b1;
                end
                ST_READY_WAIT: begin
                    if (peer_ready_i) begin
                        cap_q <= cap_new;
                        off_q <= '0;
                    end
                end
                ST_HDR_PUSH: begin
                    flen_q   <= frag_len;
                    nwords_q <= frag_words;
                    widx_q   <= '0;
                end
                ST_BODY_PUSH: begin
                    widx_q <= widx_q + 8'd1;
                    if (last_word) off_q <= LEN_W'(off_q + LEN_W'(flen_q));
                end
                ST_RETRY: begin
                    if (try_q != TRY_W'(MAX_TRIES - 1)) try_q <= try_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready_o = (state_q == ST_LOAD);
        mb_push_o  = (state_q == ST_HDR_PUSH) || (state_q == ST_BODY_PUSH);
        doorbell_o = (state_q == ST_RING);
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_DONE);
        error_o    = (state_q == ST_FAIL);
        unique case (state_q)
            ST_HDR_PUSH:  mb_word_o = pack_header(frag_last, frag_len, host_q, client_q);
            ST_BODY_PUSH: mb_word_o = body_word;
            default:      mb_word_o = 32'h0;
        endcase
    end

    AST_HDR_HAS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR_PUSH) |-> ($past(free_ext) != '0)); // R4
    AST_BODY_HAS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BODY_PUSH && $past(state_q) == ST_BODY_WAIT)
            |-> ($past(free_ext) >= words_ext)); // R4
    AST_FRAG_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR_PUSH) |-> (frag_len != '0 && frag_len <= cap_q)); // R2
    AST_BELL_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell_o |-> $past(mb_push_o)); // R6
    AST_REJECT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && msg_len_i == '0) |=> (error_o && !mb_push_o)); // R8
    AST_DONE_ALL_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (off_q == len_q)); // R10
    AST_LAST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && peer_ready_i && off_q == len_q) |-> $past(frag_last, 4)); // R3

endmodule

// File: tb/tx_frag_engine_test.sv
module tx_frag_engine_test;

    localparam int MAX_LEN    = 600;
    localparam int DEPTH_W    = 8;
    localparam int WAIT_LIMIT = 400;
    localparam int MAX_TRIES  = 5;
    localparam int LEN_W      = $clog2(MAX_LEN + 1);
    localparam int LOG_SZ     = 512;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [LEN_W-1:0]   msg_len = '0;
    logic [7:0]         host_addr = '0, client_addr = '0;
    logic               in_valid = 1'b0;
    logic [7:0]         in_data = '0;
    logic               in_ready;
    logic [DEPTH_W-1:0] mb_depth = 8'd4, mb_free = 8'd4;
    logic               peer_ready = 1'b1;
    logic               mb_push, doorbell, busy, done, error;
    logic [31:0]        mb_word;

    int checks = 0, fails = 0;
    int cyc = 0;

    logic [7:0]  msg [MAX_LEN];
    logic [31:0] exp_w [LOG_SZ];
    logic [31:0] log_w [LOG_SZ];
    int exp_n, exp_frags, log_n = 0, rings = 0, occ = 0;
    int inject_at = 0, hold = 0;
    bit drain_en = 1'b0, overflow = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    tx_frag_engine #(.MAX_LEN(MAX_LEN), .DEPTH_W(DEPTH_W),
                     .WAIT_LIMIT(WAIT_LIMIT), .MAX_TRIES(MAX_TRIES)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .msg_len_i(msg_len),
        .host_addr_i(host_addr), .client_addr_i(client_addr),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
        .mb_depth_i(mb_depth), .mb_free_i(mb_free), .peer_ready_i(peer_ready),
        .mb_push_o(mb_push), .mb_word_o(mb_word), .doorbell_o(doorbell),
        .busy_o(busy), .done_o(done), .error_o(error)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // mailbox and peer model, evaluated away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mb_push) begin
                if (log_n < LOG_SZ) log_w[log_n] = mb_word;
                log_n++;
                occ++;
            end
            if (drain_en && occ > 0 && ($urandom % 2) == 0) occ--;
            if (occ > int'(mb_depth)) overflow = 1'b1;
            if (doorbell) begin
                rings++;
                if (inject_at != 0 && rings == inject_at) begin
                    peer_ready = 1'b0;
                    hold = 12;
                    log_n = 0;
                    rings = 0;
                    inject_at = 0;
                end
            end else if (hold > 0) begin
                hold--;
                if (hold == 0) peer_ready = 1'b1;
            end
            mb_free = DEPTH_W'(int'(mb_depth) - occ);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // expected fragment stream for the current message
    task automatic build_expected(input int len, input int dep);
        int cap, off, fl, capped;
        exp_n = 0;
        exp_frags = 0;
        capped = (dep * 4 > 511) ? 511 : dep * 4;
        cap = capped - 4;
        off = 0;
        while (off < len) begin
            fl = (len - off > cap) ? cap : len - off;
            exp_w[exp_n] = {(off + fl == len), 6'b0, 9'(fl), host_addr, client_addr};
            exp_n++;
            for (int w = 0; w < (fl + 3) / 4; w++) begin
                logic [31:0] word;
                word = '0;
                for (int b = 0; b < 4; b++)
                    if (w * 4 + b < fl) word[8*b +: 8] = msg[off + w * 4 + b];
                exp_w[exp_n] = word;
                exp_n++;
            end
            off += fl;
            exp_frags++;
        end
    endtask

    task automatic run_msg(input int len, input int dep, input int inj, input bit drain,
                           input bit want_err, input string req, output int wait_cyc);
        bit got_done, got_err;
        int i, guard, hdr_idx;
        for (int k = 0; k < MAX_LEN; k++) msg[k] = 8'($urandom);
        host_addr   = 8'($urandom);
        client_addr = 8'($urandom);
        if (len > 0 && len <= MAX_LEN) build_expected(len, dep);
        @(negedge clk);
        mb_depth = DEPTH_W'(dep);
        occ = 0;
        mb_free = DEPTH_W'(dep);
        log_n = 0;
        rings = 0;
        overflow = 1'b0;
        inject_at = inj;
        drain_en = drain;
        start = 1'b1;
        msg_len = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        i = 0;
        if (len > 0 && len <= MAX_LEN) begin
            while (i < len) begin
                in_valid = (($urandom % 4) != 0);
                in_data  = msg[i];
                if (in_valid && in_ready) i++;
                @(negedge clk);
            end
            in_valid = 1'b0;
        end
        got_done = 1'b0;
        got_err = 1'b0;
        guard = 0;
        while (!got_done && !got_err && guard < 20000) begin
            if (done) got_done = 1'b1;
            if (error) got_err = 1'b1;
            if (!got_done && !got_err) begin
                @(negedge clk);
                guard++;
            end
        end
        wait_cyc = guard;
        if (want_err) begin
            check(got_err && !got_done, req, {got_done, got_err}, 2'b01);
        end else begin
            check(got_done && !got_err, "R10 done pulse", {got_done, got_err}, 2'b10);
            check(log_n == exp_n, "R2 word count", log_n, exp_n);
            hdr_idx = 0;
            for (int k = 0; k < exp_n && k < log_n; k++) begin
                if (k == hdr_idx) begin
                    check(log_w[k][30:0] == exp_w[k][30:0], "R1 header fields", log_w[k], exp_w[k]);
                    check(log_w[k][31] == exp_w[k][31], "R3 complete flag", log_w[k][31], exp_w[k][31]);
                    hdr_idx = k + 1 + (int'(exp_w[k][24:16]) + 3) / 4;
                end else begin
                    check(log_w[k] == exp_w[k], "R5 payload word", log_w[k], exp_w[k]);
                end
            end
            check(rings == exp_frags, "R6 doorbell per fragment", rings, exp_frags);
        end
        check(!overflow, "R4 no mailbox overflow", overflow, 0);
        @(negedge clk);
    endtask

    initial begin
        int w, seed_dummy;
        seed_dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        check(!in_ready && !mb_push && !doorbell && !busy && !done && !error,
              "R10 reset idle", {in_ready, mb_push, doorbell, busy, done, error}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!in_ready && !busy, "R10 idle after reset", {in_ready, busy}, 0);

        // R8: rejected lengths
        run_msg(0, 4, 0, 1'b1, 1'b1, "R8 zero length", w);
        check(log_n == 0, "R8 no push on zero length", log_n, 0);
        check(w == 0, "R8 error next cycle", w, 0);
        run_msg(MAX_LEN + 1, 4, 0, 1'b1, 1'b1, "R8 oversize length", w);
        check(log_n == 0, "R8 no push on oversize", log_n, 0);

        // directed sizes
        run_msg(1, 2, 0, 1'b1, 1'b0, "", w);       // R5 single padded byte
        run_msg(13, 3, 0, 1'b1, 1'b0, "", w);      // R2 two fragments 8+5
        run_msg(MAX_LEN, 200, 0, 1'b1, 1'b0, "", w); // R2 511 cap: 507+93
        run_msg(520, 127, 0, 1'b1, 1'b0, "", w);   // R2 cap 504 just under limit

        // R7: mid-message retry on second doorbell
        run_msg(40, 4, 2, 1'b1, 1'b0, "", w);
        run_msg(9, 2, 1, 1'b1, 1'b0, "", w);

        // R7 / R9: peer never ready
        peer_ready = 1'b0;
        hold = 0;
        run_msg(10, 4, 0, 1'b1, 1'b1, "R7 attempts exhausted", w);
        check(w >= MAX_TRIES * WAIT_LIMIT && w <= MAX_TRIES * (WAIT_LIMIT + 2) + 4,
              "R9 ready timeout span", w, MAX_TRIES * WAIT_LIMIT);
        check(log_n == 0, "R9 nothing pushed without ready", log_n, 0);
        peer_ready = 1'b1;

        // R9 / R4: slot timeout with a stalled mailbox
        run_msg(20, 4, 0, 1'b0, 1'b1, "R9 slot timeout", w);
        check(log_n == 4, "R4 only first fragment fits", log_n, 4);
        check(rings == 1, "R9 one doorbell before stall", rings, 1);

        // random messages
        for (int n = 0; n < 25; n++) begin
            int len, dep, inj;
            len = 1 + int'($urandom % 80);
            dep = 2 + int'($urandom % 11);
            build_expected(len, dep);
            inj = (($urandom % 3) == 0) ? 1 + int'($urandom % exp_frags) : 0;
            run_msg(len, dep, inj, 1'b1, 1'b0, "", w);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule